// File: doc/BRIEF.md
# Pin-Selected Power-Down Controller

This block drives the power-down enables of the analog and digital subsystems of a mixed-signal front end. It keeps two 8-bit power-down masks and one half-duplex control byte, all loaded through a small register write port. A master power pin picks which mask drives the outputs. The path from pin to outputs is purely combinational, so a pin change acts at once. Software can therefore hold two complete power settings and switch between them with a single pin.

When the mode input selects the half-duplex interface, a transmit-enable pin also gates the fast-switching transmit and receive blocks. The output amplifier and the transmit digital filter power down a programmable number of clock cycles after transmit-enable falls. A rising transmit-enable releases them at once. The receive fast blocks can be turned off while transmit-enable is high. The DAC is never touched by this mechanism. A separate active-low quiet pin turns the output amplifier off and raises a filter-disable flag in either mode.

Each final enable is the OR of its selected mask bit and any forced power-down that applies to that block.

Top module: `pwrsel_ctrl`

## Requirements
- R1: After reset, the low-select mask is 0x00, the high-select mask is 0x7F and the control byte is 0x03. With full-duplex mode and pwrSel low, every enable is 0. With pwrSel high, every enable except pdPll is 1. In half-duplex mode with txEn held low since reset, pdTxAmp and pdTxDig are 1.
- R2: The mask bit map is: bit 7 pdPll, bit 6 both pdTxDac and pdTxAmp, bit 5 pdTxDig, bit 4 pdRef, bit 3 pdAdcCm, bit 2 pdAdc, bit 1 pdPgaBias, bit 0 pdRxPga. A 1 means powered down. pwrSel low selects the mask at address 0x01 and pwrSel high selects the mask at address 0x02, combinationally with no clock delay.
- R3: A write with wrEn high to address 0x01, 0x02 or 0x03 takes effect after the next rising clock edge. Writes to any other address change nothing.
- R4: With fullDuplex high, the control byte and txEn have no effect on any output.
- R5: In half-duplex mode with control bit 1 set, let D be control bits 7:3. pdTxAmp and pdTxDig rise on the (16·D+1)-th rising edge after txEn falls, counting the first edge at which txEn is sampled low as edge 1. With D = 0 this is that first edge. pdTxDac is not forced.
- R6: A high txEn clears the transmit forcing combinationally and cancels a pending delay. After txEn falls again, the full delay starts over.
- R7: In half-duplex mode, when control bits 0 and 2 are both set, pdAdc and pdRxPga are 1 while txEn is high. No other enable is affected. With only one of those two bits set, nothing is forced.
- R8: With control bit 1 clear, txEn never forces pdTxAmp or pdTxDig.
- R9: A low txQuietN sets pdTxAmp and filtDisable in either mode and leaves pdTxDac at its mask value. filtDisable is 1 exactly while txQuietN is low.
- R10: Each enable is the OR of its mask bit and its forced power-down. In full-duplex mode, masks 0x60 and 0x05 make pwrSel alternate between transmit-off and receive-off, so the two paths are never both on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 8 | Register write address |
| wrData | input | 8 | Register write data |
| fullDuplex | input | 1 | 1 = full-duplex interface, 0 = half-duplex |
| pwrSel | input | 1 | Master power pin, selects a mask |
| txEn | input | 1 | Transmit enable |
| txQuietN | input | 1 | Active-low transmit quiet |
| pdPll | output | 1 | PLL power-down |
| pdTxDac | output | 1 | DAC power-down |
| pdTxAmp | output | 1 | Output amplifier power-down |
| pdTxDig | output | 1 | Transmit digital power-down |
| pdRef | output | 1 | Reference power-down |
| pdAdcCm | output | 1 | ADC common-mode power-down |
| pdAdc | output | 1 | ADC power-down |
| pdPgaBias | output | 1 | PGA bias power-down |
| pdRxPga | output | 1 | Receive PGA power-down |
| filtDisable | output | 1 | Interpolation filter disable |

## Verification
Pin-driven results (pwrSel, txQuietN, a rising txEn, the mode input) are due in the same cycle. The bench checks them two nanoseconds after driving them at a falling edge. Register writes are due after the one rising edge that captures them, and the bench checks them at the falling edge that follows. The delayed transmit power-down is checked on both sides of its boundary for every delay value: still on after edge 16·D, off after edge 16·D+1.

// File: rtl/pwrsel_pkg.sv
package pwrsel_pkg;
  localparam int REG_W      = 8;
  localparam int DLY_W      = 5;
  localparam int TICK_SHIFT = 4;
  localparam int CNT_W      = DLY_W + TICK_SHIFT;

  // control byte: the bit positions are software-visible
  typedef struct packed {
    logic [DLY_W-1:0] txDelay;  // bits 7:3
    logic             rxViaTx;  // bit 2
    logic             txPdEn;   // bit 1
    logic             rxPdEn;   // bit 0
  } hdCfg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic txOff;
    logic rxOff;
    logic ampOff;
    logic filtOff;
  } forceVec_t;

  typedef struct packed {
    logic pll;
    logic txDac;
    logic txAmp;
    logic txDig;
    logic ref_;
    logic adcCm;
    logic adc;
    logic pgaBias;
    logic rxPga;
    logic filtDis;
  } pdOut_t;
endpackage

// File: rtl/pwrsel_seq.sv
module pwrsel_seq
  import pwrsel_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      halfDuplex,
  input  logic      txEn,
  input  logic      txQuietN,
  input  hdCfg_t    hdCfg,
  output forceVec_t forceVec
);
  logic             txEnQ;
  logic             txOffQ;
  logic             pending;
  logic [CNT_W-1:0] cnt;
  logic             txFall;

  assign txFall = txEnQ & ~txEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txEnQ   <= 1'b0;
      txOffQ  <= 1'b1;
      pending <= 1'b0;
      cnt     <= '0;
    end else begin
      txEnQ <= txEn;
      if (txEn) begin
        txOffQ  <= 1'b0;
        pending <= 1'b0;
      end else if (txFall) begin
        if (hdCfg.txDelay == '0) begin
          txOffQ <= 1'b1;
        end else begin
          pending <= 1'b1;
          cnt     <= {hdCfg.txDelay, {TICK_SHIFT{1'b0}}};
        end
      end else if (pending) begin
        if (cnt == CNT_W'(1)) begin
          txOffQ  <= 1'b1;
          pending <= 1'b0;
        end else begin
          cnt <= cnt - CNT_W'(1);
        end
      end
    end
  end

  always_comb begin
    forceVec.txOff   = halfDuplex & hdCfg.txPdEn & txOffQ & ~txEn;
    forceVec.rxOff   = halfDuplex & hdCfg.rxPdEn & hdCfg.rxViaTx & txEn;
    forceVec.filtOff = ~txQuietN;
    forceVec.ampOff  = forceVec.txOff | ~txQuietN;
  end
endmodule

// File: rtl/pwrsel_regs.sv
module pwrsel_regs
  import pwrsel_pkg::*;
#(
  parameter int             ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] LO_ADDR = ADDR_W'(1),
  parameter logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(2),
  parameter logic [ADDR_W-1:0] HD_ADDR = ADDR_W'(3),
  parameter logic [REG_W-1:0]  LO_RST  = 8'h00,
  parameter logic [REG_W-1:0]  HI_RST  = 8'h7F,
  parameter logic [REG_W-1:0]  HD_RST  = 8'h03
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [REG_W-1:0]  wrData,
  input  logic              pwrSel,
  input  forceVec_t         forceVec,
  output hdCfg_t            hdCfg,
  output pdOut_t            pdOut
);
  logic [REG_W-1:0] maskLo, maskHi, hdReg, selMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskLo <= LO_RST;
      maskHi <= HI_RST;
      hdReg  <= HD_RST;
    end else if (wrEn) begin
      if (wrAddr == LO_ADDR) maskLo <= wrData;
      if (wrAddr == HI_ADDR) maskHi <= wrData;
      if (wrAddr == HD_ADDR) hdReg  <= wrData;
    end
  end

  assign hdCfg   = hdCfg_t'(hdReg);
  assign selMask = pwrSel ? maskHi : maskLo;

  always_comb begin
    pdOut.pll     = selMask[7];
    pdOut.txDac   = selMask[6];
    pdOut.txAmp   = selMask[6] | forceVec.ampOff;
    pdOut.txDig   = selMask[5] | forceVec.txOff;
    pdOut.ref_    = selMask[4];
    pdOut.adcCm   = selMask[3];
    pdOut.adc     = selMask[2] | forceVec.rxOff;
    pdOut.pgaBias = selMask[1];
    pdOut.rxPga   = selMask[0] | forceVec.rxOff;
    pdOut.filtDis = forceVec.filtOff;
  end
endmodule

// File: rtl/pwrsel_ctrl.sv
module pwrsel_ctrl
  import pwrsel_pkg::*;
#(
  parameter int ADDR_W = 8
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [REG_W-1:0]  wrData,
  input  logic              fullDuplex,
  input  logic              pwrSel,
  input  logic              txEn,
  input  logic              txQuietN,
  output logic              pdPll,
  output logic              pdTxDac,
  output logic              pdTxAmp,
  output logic              pdTxDig,
  output logic              pdRef,
  output logic              pdAdcCm,
  output logic              pdAdc,
  output logic              pdPgaBias,
  output logic              pdRxPga,
  output logic              filtDisable
);
  hdCfg_t    hdCfg;
  forceVec_t forceVec;
  pdOut_t    pdOut;

  pwrsel_seq u_seq (
    .clk(clk), .rstN(rstN), .halfDuplex(~fullDuplex), .txEn(txEn),
    .txQuietN(txQuietN), .hdCfg(hdCfg), .forceVec(forceVec)
  );

  pwrsel_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pwrSel(pwrSel), .forceVec(forceVec), .hdCfg(hdCfg), .pdOut(pdOut)
  );

  assign pdPll       = pdOut.pll;
  assign pdTxDac     = pdOut.txDac;
  assign pdTxAmp     = pdOut.txAmp;
  assign pdTxDig     = pdOut.txDig;
  assign pdRef       = pdOut.ref_;
  assign pdAdcCm     = pdOut.adcCm;
  assign pdAdc       = pdOut.adc;
  assign pdPgaBias   = pdOut.pgaBias;
  assign pdRxPga     = pdOut.rxPga;
  assign filtDisable = pdOut.filtDis;
endmodule

// File: rtl/pwrsel_chk.sv
module pwrsel_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic       fullDuplex,
  input logic       txEn,
  input logic       txQuietN,
  input logic       pdTxAmp,
  input logic       pdTxDac,
  input logic       pdTxDig,
  input logic       filtDisable,
  input logic [4:0] txDelay,
  input logic       txPdEn
);
  p_quiet_forces_amp_r9: assert property (@(posedge clk) disable iff (!rstN)
    !txQuietN |-> (pdTxAmp && filtDisable));

  p_full_amp_tracks_dac_r4: assert property (@(posedge clk) disable iff (!rstN)
    (fullDuplex && txQuietN) |-> (pdTxAmp == pdTxDac));

  p_txen_releases_amp_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!fullDuplex && txEn && txQuietN) |-> (pdTxAmp == pdTxDac));

  p_zero_delay_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!fullDuplex && !wrEn && txPdEn && txDelay == 5'd0 && $past(rstN) &&
     $past(txEn) && !txEn) |=> (txEn || fullDuplex || pdTxDig));
endmodule

bind pwrsel_ctrl pwrsel_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .fullDuplex(fullDuplex),
  .txEn(txEn), .txQuietN(txQuietN), .pdTxAmp(pdTxAmp), .pdTxDac(pdTxDac),
  .pdTxDig(pdTxDig), .filtDisable(filtDisable),
  .txDelay(hdCfg.txDelay), .txPdEn(hdCfg.txPdEn)
);

// File: tb/pwrsel_ctrl_tb.sv
module pwrsel_ctrl_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       fullDuplex = 1'b1;
  logic       pwrSel = 1'b0;
  logic       txEn = 1'b0;
  logic       txQuietN = 1'b1;
  logic pdPll, pdTxDac, pdTxAmp, pdTxDig, pdRef, pdAdcCm, pdAdc, pdPgaBias, pdRxPga, filtDisable;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  int cycles = 0;

  always #10 clk = ~clk;

  pwrsel_ctrl u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .fullDuplex(fullDuplex), .pwrSel(pwrSel), .txEn(txEn), .txQuietN(txQuietN),
    .pdPll(pdPll), .pdTxDac(pdTxDac), .pdTxAmp(pdTxAmp), .pdTxDig(pdTxDig),
    .pdRef(pdRef), .pdAdcCm(pdAdcCm), .pdAdc(pdAdc), .pdPgaBias(pdPgaBias),
    .pdRxPga(pdRxPga), .filtDisable(filtDisable)
  );

  function automatic logic [9:0] outs();
    return {pdPll, pdTxDac, pdTxAmp, pdTxDig, pdRef, pdAdcCm, pdAdc, pdPgaBias, pdRxPga, filtDisable};
  endfunction

  function automatic logic [9:0] ev(logic [7:0] m, logic txF, logic rxF, logic quiet);
    return {m[7], m[6], m[6] | txF | quiet, m[5] | txF, m[4], m[3],
            m[2] | rxF, m[1], m[0] | rxF, quiet};
  endfunction

  task automatic chk(string tag, logic [9:0] got, logic [9:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    #2;
  endtask

  task automatic settle();
    @(negedge clk);
    #2;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    settle();
    // R1 reset state in full-duplex mode
    chk("R1 reset lo mask", outs(), ev(8'h00, 0, 0, 0));
    pwrSel = 1'b1; #2;
    chk("R1 reset hi mask", outs(), ev(8'h7F, 0, 0, 0));
    pwrSel = 1'b0; #2;
    // R1 control byte default: half-duplex with txEn low since reset
    fullDuplex = 1'b0; #2;
    chk("R1 reset control default", outs(), ev(8'h00, 1, 0, 0));
    fullDuplex = 1'b1; #2;

    // R2 exhaustive mask sweep with pin selection
    for (int v = 0; v < 256; v++) begin
      wr(8'h01, 8'(v));
      wr(8'h02, ~8'(v));
      pwrSel = 1'b0; #2;
      chk("R2 lo mask sweep", outs(), ev(8'(v), 0, 0, 0));
      pwrSel = 1'b1; #2;
      chk("R2 hi mask sweep", outs(), ev(~8'(v), 0, 0, 0));
    end
    pwrSel = 1'b0;

    // R3 writes to unused addresses are ignored
    wr(8'h01, 8'h5A);
    wr(8'h02, 8'hA5);
    wr(8'h00, 8'hFF);
    wr(8'h04, 8'hFF);
    wr(8'h83, 8'hFF);
    #2;
    chk("R3 stray write lo", outs(), ev(8'h5A, 0, 0, 0));
    pwrSel = 1'b1; #2;
    chk("R3 stray write hi", outs(), ev(8'hA5, 0, 0, 0));
    pwrSel = 1'b0;
    wr(8'h01, 8'h00);
    wr(8'h02, 8'h00);

    // R4 full-duplex ignores control byte and txEn
    wr(8'h03, 8'h07);
    txEn = 1'b1; settle();
    chk("R4 full txEn high", outs(), ev(8'h00, 0, 0, 0));
    txEn = 1'b0; repeat (3) settle();
    chk("R4 full txEn low", outs(), ev(8'h00, 0, 0, 0));

    // R9 quiet pin in both modes
    txQuietN = 1'b0; #2;
    chk("R9 quiet full", outs(), ev(8'h00, 0, 0, 1));
    wr(8'h01, 8'h40); #2;
    chk("R9 quiet with dac mask", outs(), ev(8'h40, 0, 0, 1));
    wr(8'h01, 8'h00);
    txQuietN = 1'b1; #2;
    chk("R9 quiet released", outs(), ev(8'h00, 0, 0, 0));

    // R5 delay sweep over every delay value
    fullDuplex = 1'b0;
    for (int d = 0; d < 32; d++) begin
      wr(8'h03, {5'(d), 3'b010});
      txEn = 1'b1; settle();
      chk("R5 tx on before fall", outs(), ev(8'h00, 0, 0, 0));
      @(negedge clk);
      txEn = 1'b0;
      repeat (16 * d) @(negedge clk);
      #2;
      chk($sformatf("R5 delay %0d before boundary", d), outs(), ev(8'h00, 0, 0, 0));
      @(negedge clk); #2;
      chk($sformatf("R5 delay %0d after boundary", d), outs(), ev(8'h00, 1, 0, 0));
    end

    // R6 cancel and restart
    wr(8'h03, {5'd3, 3'b010});
    txEn = 1'b1; settle();
    @(negedge clk); txEn = 1'b0;
    repeat (20) @(negedge clk);
    txEn = 1'b1; #2;
    chk("R6 cancel pending", outs(), ev(8'h00, 0, 0, 0));
    @(negedge clk); txEn = 1'b0;
    repeat (40) @(negedge clk); #2;
    chk("R6 restart still on", outs(), ev(8'h00, 0, 0, 0));
    @(negedge clk); txEn = 1'b1; #2;
    chk("R6 immediate release", outs(), ev(8'h00, 0, 0, 0));
    @(negedge clk); txEn = 1'b0;
    repeat (48) @(negedge clk); #2;
    chk("R6 restart edge 48", outs(), ev(8'h00, 0, 0, 0));
    @(negedge clk); #2;
    chk("R6 restart edge 49", outs(), ev(8'h00, 1, 0, 0));
    txEn = 1'b1; #2;
    chk("R6 release after off", outs(), ev(8'h00, 0, 0, 0));

    // R7 and R8 receive forcing, transmit forcing disabled
    wr(8'h03, 8'b00000_101);
    txEn = 1'b1; settle();
    chk("R7 rx forced while txEn high", outs(), ev(8'h00, 0, 1, 0));
    txEn = 1'b0; #2;
    chk("R7 rx released", outs(), ev(8'h00, 0, 0, 0));
    repeat (3) settle();
    chk("R8 no tx forcing with bit1 clear", outs(), ev(8'h00, 0, 0, 0));
    wr(8'h03, 8'b00000_100);
    txEn = 1'b1; settle();
    chk("R7 bit2 alone no force", outs(), ev(8'h00, 0, 0, 0));
    wr(8'h03, 8'b00000_001); #2;
    chk("R7 bit0 alone no force", outs(), ev(8'h00, 0, 0, 0));
    txEn = 1'b0;

    // R10 OR combination and alternating paths in full-duplex mode
    fullDuplex = 1'b1;
    wr(8'h01, 8'h60);
    wr(8'h02, 8'h05);
    for (int k = 0; k < 4; k++) begin
      pwrSel = k[0]; #2;
      chk("R10 alternate paths", outs(), pwrSel ? ev(8'h05, 0, 0, 0) : ev(8'h60, 0, 0, 0));
    end
    fullDuplex = 1'b0; pwrSel = 1'b1;
    wr(8'h03, 8'b00000_111);
    txEn = 1'b1; settle();
    chk("R10 mask or rx force", outs(), ev(8'h05, 0, 1, 0));
    txQuietN = 1'b0; #2;
    chk("R10 mask or quiet", outs(), ev(8'h05, 0, 1, 1));
    txQuietN = 1'b1;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule